// File: doc/BRIEF.md
# Whole-Group Stream Buffer

This block sits between a packet source and a piece of user processing logic that consumes words in groups of N (for example, N input words per output sample of a decimator). Words enter on a valid/ready input together with a group-boundary mark and a pass-through end-of-packet flag. The block holds each group in a small memory and releases it only once the group is complete. A group cut short by an early mark or by a flush strobe is rolled back and never leaves the block, so the consumer is never left holding a stranded fraction of a group.

The group size N is loaded through a simple settings-bus write at a parameterised address. A new value is staged and becomes active only at a group boundary, so a group already in progress finishes with the size it started with. A synchronous clear empties the buffer completely. The surrounding logic uses it once a burst has drained. A flush discards only the uncommitted tail, and whole groups that are already committed are still delivered.

Back-pressure rules: a word is transferred on either side only in a cycle where valid and ready are both high. The input side is ready whenever the memory (a power of two of at least 2·MAX_GRP entries) is not full. The output side holds valid and data steady until the consumer takes the word. Neither ready depends combinationally on the other side's valid.

Top module: `grp_gate_buf`

## Requirements
- R1: No word of a group is presented at the output until the N-th word of that group has been accepted. Committed words appear in acceptance order, with `out_valid` high from the cycle after the accepting clock edge of the N-th word.
- R2: If `in_mark` is high on an accepted word that is word k of its group with k < N, that word and the k-1 earlier words of the group are discarded.
- R3: The group commits when its N-th word is accepted, whether or not `in_mark` is high on that word.
- R4: A `flush` pulse discards every uncommitted word, and the next accepted word starts a new group. Committed words are still delivered.
- R5: A `clr` pulse empties the buffer: `out_valid` is low and `in_ready` is high in the following cycle. The active N is kept.
- R6: A write with `cfg_we` high, `cfg_addr` equal to SET_ADDR (default 0x04) and `cfg_wdata` in 1..MAX_GRP stages a new N. Writes of 0, writes above MAX_GRP and writes to any other address have no effect.
- R7: A staged N becomes active only when no group is in progress. A group already holding words completes with the N it started with.
- R8: The `in_pend` bit accepted with each word comes out on `out_pend` with that same word.
- R9: `in_ready` is low exactly when DEPTH words are held (committed or uncommitted, not yet read). While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R10: After reset, `out_valid` is low, `in_ready` is high and N equals DEF_GRP (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of all buffer state |
| flush | input | 1 | Discard the uncommitted tail |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | CFG_AW (8) | Settings write address |
| cfg_wdata | input | CFG_DW (32) | Settings write data (group size) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input can accept a word |
| in_data | input | DW (16) | Input word |
| in_pend | input | 1 | End-of-packet flag carried with the word |
| in_mark | input | 1 | Group boundary / end of burst mark |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DW (16) | Output word |
| out_pend | output | 1 | End-of-packet flag of the output word |

## Verification
The assertions assume that `clr`, `flush` and settings writes are single-cycle control pulses that are low during reset, and that the consumer obeys ordinary valid/ready rules. They also assume nothing about the timing of `in_mark` beyond its being sampled only on accepted words. The stimulus drives every input at the falling edge, asserts `clr` only while the output is held off, and writes a new N only between groups, except for one directed case that writes in the middle of a group. The scoreboard models group completion, early marks, flushes and staged sizes independently of the design.

// File: rtl/grp_buf_pkg.sv
package grp_buf_pkg;
  // Outcome of a cycle for the group in progress
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_COMMIT = 2'd1,
    EV_DROP   = 2'd2
  } grp_ev_e;
endpackage

// File: rtl/grp_size_reg.sv
module grp_size_reg #(
  parameter int MAX_GRP  = 16,
  parameter int DEF_GRP  = 4,
  parameter int CFG_AW   = 8,
  parameter int CFG_DW   = 32,
  parameter int SET_ADDR = 4,
  localparam int GW      = $clog2(MAX_GRP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              grp_idle,
  output logic [GW-1:0]     n_use
);
  logic [GW-1:0] n_stage;
  logic [GW-1:0] n_act;
  logic          wr_ok;

  assign wr_ok = cfg_we && (cfg_addr == CFG_AW'(SET_ADDR)) &&
                 (cfg_wdata != '0) && (cfg_wdata <= CFG_DW'(MAX_GRP));

  // Staged value only takes over between groups
  assign n_use = grp_idle ? n_stage : n_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_stage <= GW'(DEF_GRP);
      n_act   <= GW'(DEF_GRP);
    end else begin
      if (wr_ok) n_stage <= cfg_wdata[GW-1:0];
      n_act <= n_use;
    end
  end

  AST_N_RANGE: assert property (@(posedge clk) disable iff (rst)
    (n_use != '0) && (n_use <= GW'(MAX_GRP)));  // R6

  AST_N_HELD: assert property (@(posedge clk) disable iff (rst)
    !grp_idle |=> (n_act == $past(n_act)));  // R7
endmodule

// File: rtl/grp_tracker.sv
module grp_tracker
  import grp_buf_pkg::*;
#(
  parameter int MAX_GRP = 16,
  localparam int GW     = $clog2(MAX_GRP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          flush,
  input  logic          accept,
  input  logic          mark,
  input  logic [GW-1:0] n_use,
  output grp_ev_e       ev,
  output logic          grp_idle
);
  logic [GW-1:0] cnt;
  logic          last_word;

  assign last_word = (cnt + GW'(1)) == n_use;
  assign grp_idle  = (cnt == '0);

  always_comb begin
    ev = EV_NONE;
    if (flush)           ev = EV_DROP;
    else if (accept) begin
      if (last_word)     ev = EV_COMMIT;
      else if (mark)     ev = EV_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)            cnt <= '0;
    else if (ev != EV_NONE)    cnt <= '0;
    else if (accept)           cnt <= cnt + GW'(1);
  end

  AST_CNT_BELOW_N: assert property (@(posedge clk) disable iff (rst)
    cnt < n_use);  // R3
endmodule

// File: rtl/grp_store.sv
module grp_store #(
  parameter int EW    = 17,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/grp_gate_buf.sv
module grp_gate_buf
  import grp_buf_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MAX_GRP  = 16,
  parameter int DEF_GRP  = 4,
  parameter int CFG_AW   = 8,
  parameter int CFG_DW   = 32,
  parameter int SET_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              flush,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_pend,
  input  logic              in_mark,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_pend
);
  localparam int GW    = $clog2(MAX_GRP + 1);
  localparam int DEPTH = 2 ** $clog2(2 * MAX_GRP);
  localparam int PW    = $clog2(DEPTH);
  localparam int EW    = DW + 1;

  logic [PW:0]   wr_ptr, cmt_ptr, rd_ptr;
  logic [PW:0]   used;
  logic          accept, take, grp_idle;
  logic [GW-1:0] n_use;
  logic [EW-1:0] rd_word;
  grp_ev_e       ev;

  assign used      = wr_ptr - rd_ptr;
  assign in_ready  = (used != (PW+1)'(DEPTH));
  assign accept    = in_valid && in_ready;
  assign out_valid = (rd_ptr != cmt_ptr);
  assign take      = out_valid && out_ready;
  assign {out_pend, out_data} = rd_word;

  grp_size_reg #(
    .MAX_GRP(MAX_GRP), .DEF_GRP(DEF_GRP), .CFG_AW(CFG_AW),
    .CFG_DW(CFG_DW), .SET_ADDR(SET_ADDR)
  ) u_size (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .grp_idle(grp_idle), .n_use(n_use)
  );

  grp_tracker #(.MAX_GRP(MAX_GRP)) u_track (
    .clk(clk), .rst(rst), .clr(clr), .flush(flush), .accept(accept),
    .mark(in_mark), .n_use(n_use), .ev(ev), .grp_idle(grp_idle)
  );

  grp_store #(.EW(EW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(accept), .waddr(wr_ptr[PW-1:0]),
    .wdata({in_pend, in_data}), .raddr(rd_ptr[PW-1:0]), .rdata(rd_word)
  );

  // Write side: advance on accept, roll back to the commit point on drop
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
    end else begin
      case (ev)
        EV_DROP:   wr_ptr <= cmt_ptr;
        EV_COMMIT: begin
          wr_ptr  <= wr_ptr + 1'b1;
          cmt_ptr <= wr_ptr + 1'b1;
        end
        default:   if (accept) wr_ptr <= wr_ptr + 1'b1;
      endcase
    end
  end

  // Read side: only committed words are visible
  always_ff @(posedge clk) begin
    if (rst || clr)  rd_ptr <= '0;
    else if (take)   rd_ptr <= rd_ptr + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    used <= (PW+1)'(DEPTH));  // R9

  AST_READ_BEHIND_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (cmt_ptr - rd_ptr) <= used);  // R1

  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmt_ptr != $past(cmt_ptr)) && !$past(clr) |->
      ((cmt_ptr - $past(cmt_ptr)) == (PW+1)'($past(n_use))));  // R1

  AST_FLUSH_ROLLBACK: assert property (@(posedge clk) disable iff (rst)
    flush |=> (wr_ptr == cmt_ptr));  // R4

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_valid && in_ready));  // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !clr |=> out_valid && $stable(out_data) && $stable(out_pend));  // R9
endmodule

// File: tb/grp_gate_buf_bench.sv
module grp_gate_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW       = 16;
  localparam int MAX_GRP  = 16;
  localparam int DEF_GRP  = 4;
  localparam int SET_ADDR = 4;
  localparam int DEPTH    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          flush = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_pend = 1'b0;
  logic          in_mark = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_pend;

  grp_gate_buf #(.DW(DW), .MAX_GRP(MAX_GRP), .DEF_GRP(DEF_GRP), .SET_ADDR(SET_ADDR)) u_grp_gate_buf (
    .clk(clk), .rst(rst), .clr(clr), .flush(flush), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_pend(in_pend),
    .in_mark(in_mark), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_pend(out_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int got = 0;
  int n_model = DEF_GRP;
  int n_stage = DEF_GRP;
  int word_no = 0;
  bit hold_out = 1'b1;
  bit finished = 1'b0;
  logic [DW:0] exp_q[$];
  logic [DW:0] grp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: choose out_ready, then score the word taken at the next edge
  always @(negedge clk) begin
    out_ready = hold_out ? 1'b0 : ($urandom % 4 != 0);
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected word", int'({out_pend, out_data}), -1);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk({out_pend, out_data} == e, "R8 R1 order/data", int'({out_pend, out_data}), int'(e));
      end
      got++;
    end
  end

  // Reference model of one accepted word (R1, R2, R3, R7)
  function automatic void model_accept(input logic [DW:0] w, input logic mk);
    if (grp_q.size() == 0) n_model = n_stage;
    grp_q.push_back(w);
    if (grp_q.size() == n_model) begin
      foreach (grp_q[i]) exp_q.push_back(grp_q[i]);
      grp_q.delete();
    end else if (mk) begin
      grp_q.delete();
    end
  endfunction

  task automatic send_word(input logic mk, input int stall_pct);
    logic p;
    while (($urandom % 100) < stall_pct) @(negedge clk);
    p = ($urandom % 5 == 0);
    in_valid = 1'b1;
    in_data  = DW'(word_no);
    in_pend  = p;
    in_mark  = mk;
    while (!in_ready) @(negedge clk);
    model_accept({p, DW'(word_no)}, mk);
    word_no++;
    @(negedge clk);
    in_valid = 1'b0;
    in_mark  = 1'b0;
  endtask

  task automatic send_n(input int cnt, input bit mark_last);
    for (int i = 0; i < cnt; i++) send_word(mark_last && (i == cnt - 1), 0);
  endtask

  task automatic cfg_write(input int addr, input int val);
    cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 32'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr == SET_ADDR && val >= 1 && val <= MAX_GRP) n_stage = val;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    grp_q.delete();
  endtask

  task automatic drain();
    hold_out = 1'b0;
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 drain", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int g0;
    logic [DW:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);

    // R1, R3: group of default size 4, last word unmarked
    hold_out = 1'b1;
    g0 = got;
    send_n(3, 1'b0);
    chk(out_valid == 1'b0, "R1 partial held", out_valid, 0);
    send_n(1, 1'b0);
    chk(out_valid == 1'b1, "R3 commit on Nth", out_valid, 1);
    drain();
    chk(got - g0 == 4, "R10 default N=4", got - g0, 4);

    // R2: early mark drops the group
    hold_out = 1'b1;
    g0 = got;
    send_n(2, 1'b1);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R2 early mark", out_valid, 0);
    send_n(4, 1'b1);
    drain();
    chk(got - g0 == 4, "R2 only whole group", got - g0, 4);

    // R4: flush discards tail, committed group survives
    hold_out = 1'b1;
    g0 = got;
    send_n(6, 1'b0);
    do_flush();
    drain();
    chk(got - g0 == 4, "R4 flush tail", got - g0, 4);
    g0 = got;
    send_n(4, 1'b0);
    drain();
    chk(got - g0 == 4, "R4 restart after flush", got - g0, 4);

    // R5: clear empties, keeps N
    hold_out = 1'b1;
    send_n(4, 1'b0);
    chk(out_valid == 1'b1, "R5 pre-clear", out_valid, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    grp_q.delete();
    exp_q.delete();
    chk(out_valid == 1'b0, "R5 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R5 in_ready", in_ready, 1);
    g0 = got;
    send_n(4, 1'b0);
    drain();
    chk(got - g0 == 4, "R5 N kept", got - g0, 4);

    // R6: bad writes ignored, good write taken
    cfg_write(SET_ADDR, 0);
    cfg_write(SET_ADDR, MAX_GRP + 4);
    cfg_write(SET_ADDR + 1, 2);
    hold_out = 1'b1;
    send_n(3, 1'b0);
    chk(out_valid == 1'b0, "R6 ignored writes", out_valid, 0);
    send_n(1, 1'b0);
    chk(out_valid == 1'b1, "R6 N still 4", out_valid, 1);
    drain();
    cfg_write(SET_ADDR, 3);
    hold_out = 1'b1;
    send_n(3, 1'b0);
    chk(out_valid == 1'b1, "R6 N=3 taken", out_valid, 1);
    drain();

    // R7: write mid-group applies to the next group
    hold_out = 1'b1;
    send_n(1, 1'b0);
    cfg_write(SET_ADDR, 5);
    send_n(2, 1'b0);
    chk(out_valid == 1'b1, "R7 old N finishes", out_valid, 1);
    drain();
    hold_out = 1'b1;
    send_n(4, 1'b0);
    chk(out_valid == 1'b0, "R7 new N pending", out_valid, 0);
    send_n(1, 1'b0);
    chk(out_valid == 1'b1, "R7 new N=5", out_valid, 1);
    drain();

    // R9: fill the memory, back-pressure and output hold
    cfg_write(SET_ADDR, 4);
    hold_out = 1'b1;
    send_n(DEPTH, 1'b0);
    chk(in_ready == 1'b0, "R9 full", in_ready, 0);
    snap = {out_pend, out_data};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid held", out_valid, 1);
    chk({out_pend, out_data} == snap, "R9 data held", int'({out_pend, out_data}), int'(snap));
    drain();
    chk(in_ready == 1'b1, "R9 ready after drain", in_ready, 1);

    // Random bursts with stalls on both sides (R1, R2, R8)
    for (int b = 0; b < 40; b++) begin
      int nn, len;
      nn  = 1 + ($urandom % MAX_GRP);
      len = 1 + ($urandom % 40);
      cfg_write(SET_ADDR, nn);
      hold_out = 1'b0;
      g0 = got;
      for (int i = 0; i < len; i++)
        send_word(((i + 1) % nn == 0) || (i == len - 1), 30);
      drain();
      chk(got - g0 == (len / nn) * nn, "R1 burst multiple of N", got - g0, (len / nn) * nn);
    end

    finish_run();
  end
endmodule